// File: doc/BRIEF.md
# Self-Recovering Modulo-5 Counter

This block is a three-bit synchronous counter that cycles through the five values 0, 1, 2, 3, 4 and then wraps to 0. The three remaining codes (5, 6 and 7) never occur in normal counting. They can still appear after an upset, a glitch or a test preload, so the block's behaviour from those codes is fully specified.

A build-time parameter selects one of two next-state equation sets. The minimised set treats the unused codes as don't-cares. Each unused code then reaches a defined value inside the counting loop after one clock. The gated set qualifies every equation with the inverse of the most significant bit, so every unused code returns to 0 after one clock. Both sets give the same sequence for the five legal values.

A preload port, intended for test, writes any three-bit value into the state register. The bench uses it to place the counter in each unused code.

Top module: `mod5_recover_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, `count` is 000 after that edge. This takes priority over `preload_en`.
- R2: With `rst` and `preload_en` low, the legal values step once per clock as 000→001→010→011→100→000.
- R3: With `EQ_SET` = `EQ_MIN` (the don't-care minimised equations A⁺=B·C, B⁺=B xor C, C⁺=A'·C', where A is bit 2 and C is bit 0), the next values are: 101 steps to 010, 110 steps to 010, and 111 steps to 100.
- R4: With `EQ_SET` = `EQ_GATED` (the equations A⁺=A'·B·C, B⁺=A'·(B xor C), C⁺=A'·C'), each of 101, 110 and 111 steps to 000.
- R5: When `preload_en` is high and `rst` is low at a rising edge, `count` takes the value of `preload_val` after that edge. Unused codes can be loaded.
- R6: From reset, with no preload, both equation sets produce identical `count` sequences.
- R7: From any state, one clock with `rst` and `preload_en` low leaves `count` in the legal range 000..100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to 000 |
| preload_en | input | 1 | Test preload strobe: loads `preload_val` at the next edge |
| preload_val | input | 3 | Value to be loaded; any code, including unused ones |
| count | output | 3 | Registered counter state, bit 2 = A, bit 0 = C |

## Verification
The assertions assume that `rst` is high from time zero until the first clock edge, so that `count` is never unknown when a property samples it. The successor properties also assume that `preload_en` is low in the cycle being checked. The bench holds reset over the first edges. It drives `preload_en` only in dedicated cycles and releases it before the cycle in which recovery from an unused code is observed. A two-instance bench, one instance for each equation set, runs the same stimulus and lets the legal sequences be compared directly.

// File: rtl/mod5_pkg.sv
package mod5_pkg;

    localparam int CNT_W    = 3;
    localparam int MODULUS  = 5;
    localparam int LAST_VAL = MODULUS - 1;

    typedef enum logic {
        EQ_MIN   = 1'b0,
        EQ_GATED = 1'b1
    } eqset_e;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
    } cnt_s;

    // Don't-care minimised next-state equations
    function automatic cnt_s next_min(input cnt_s s);
        cnt_s n;
        n.a = s.b & s.c;
        n.b = s.b ^ s.c;
        n.c = ~s.a & ~s.c;
        return n;
    endfunction

    // Equations qualified by A' so that every code with A set clears
    function automatic cnt_s next_gated(input cnt_s s);
        cnt_s n;
        n.a = ~s.a & s.b & s.c;
        n.b = ~s.a & (s.b ^ s.c);
        n.c = ~s.a & ~s.c;
        return n;
    endfunction

endpackage

// File: rtl/mod5_next_logic.sv
module mod5_next_logic
    import mod5_pkg::*;
#(
    parameter eqset_e EQ_SET = EQ_MIN
) (
    input  cnt_s cur,
    output cnt_s nxt
);

    generate
        if (EQ_SET == EQ_MIN) begin : g_min
            assign nxt = next_min(cur);
        end else begin : g_gated
            assign nxt = next_gated(cur);
        end
    endgenerate

endmodule

// File: rtl/mod5_state_reg.sv
module mod5_state_reg
    import mod5_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ld,
    input  cnt_s ld_val,
    input  cnt_s nxt,
    output cnt_s q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (ld)
            q <= ld_val;
        else
            q <= nxt;
    end

endmodule

// File: rtl/mod5_recover_counter.sv
module mod5_recover_counter
    import mod5_pkg::*;
#(
    parameter eqset_e EQ_SET = EQ_MIN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             preload_en,
    input  logic [CNT_W-1:0] preload_val,
    output logic [CNT_W-1:0] count
);

    cnt_s state_q;
    cnt_s state_d;
    cnt_s load_s;

    assign load_s = cnt_s'(preload_val);

    mod5_next_logic #(.EQ_SET(EQ_SET)) u_next (
        .cur (state_q),
        .nxt (state_d)
    );

    mod5_state_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .ld     (preload_en),
        .ld_val (load_s),
        .nxt    (state_d),
        .q      (state_q)
    );

    assign count = state_q;

endmodule

// File: rtl/mod5_counter_chk.sv
module mod5_counter_chk
    import mod5_pkg::*;
#(
    parameter eqset_e EQ_SET = EQ_MIN
) (
    input logic             clk,
    input logic             rst,
    input logic             preload_en,
    input logic [CNT_W-1:0] preload_val,
    input logic [CNT_W-1:0] count
);

    // R1: reset clears the counter, ahead of any preload
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (count == 3'd0));

    // R2: legal values advance by one and wrap after 4
    a_r2_legal_step: assert property (@(posedge clk) disable iff (rst)
        (!preload_en && count <= 3'd4) |=>
            (count == (($past(count) == 3'd4) ? 3'd0 : $past(count) + 3'd1)));

    // R5: a preload lands on the next edge
    a_r5_preload: assert property (@(posedge clk) disable iff (rst)
        preload_en |=> (count == $past(preload_val)));

    // R7: a free-running clock always leaves the counter in the legal range
    a_r7_legal_after_step: assert property (@(posedge clk) disable iff (rst)
        !preload_en |=> (count <= 3'd4));

    generate
        if (EQ_SET == EQ_MIN) begin : g_min_chk
            // R3: minimised set successors of the unused codes
            a_r3_unused_to_two: assert property (@(posedge clk) disable iff (rst)
                (!preload_en && (count == 3'b101 || count == 3'b110)) |=> (count == 3'b010));
            a_r3_seven_to_four: assert property (@(posedge clk) disable iff (rst)
                (!preload_en && count == 3'b111) |=> (count == 3'b100));
        end else begin : g_gated_chk
            // R4: gated set returns every unused code to zero
            a_r4_unused_to_zero: assert property (@(posedge clk) disable iff (rst)
                (!preload_en && count > 3'd4) |=> (count == 3'd0));
        end
    endgenerate

endmodule

bind mod5_recover_counter mod5_counter_chk #(.EQ_SET(EQ_SET)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .preload_en  (preload_en),
    .preload_val (preload_val),
    .count       (count)
);

// File: tb/sim_mod5_recover_counter.sv
`timescale 1ns/1ps
module sim_mod5_recover_counter;
    import mod5_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pe  = 1'b0;
    logic [2:0] pv  = 3'd0;
    logic [2:0] cnt_min, cnt_gat;

    int checks = 0;
    int errors = 0;
    int m_min  = 0;
    int m_gat  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mod5_recover_counter #(.EQ_SET(EQ_MIN)) u0 (
        .clk(clk), .rst(rst), .preload_en(pe), .preload_val(pv), .count(cnt_min)
    );

    mod5_recover_counter #(.EQ_SET(EQ_GATED)) u1 (
        .clk(clk), .rst(rst), .preload_en(pe), .preload_val(pv), .count(cnt_gat)
    );

    // Behavioural successor of an integer state
    function automatic int ref_next(input int s, input bit gated);
        if (s < 4)  return s + 1;
        if (s == 4) return 0;
        if (gated)  return 0;
        if (s == 7) return 4;
        return 2;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Apply inputs for one edge, advance the model, compare both instances
    task automatic step(input bit r, input bit p, input int v, input string req);
        rst = r;
        pe  = p;
        pv  = v[2:0];
        @(posedge clk);
        #1;
        if (r) begin
            m_min = 0;
            m_gat = 0;
        end else if (p) begin
            m_min = v;
            m_gat = v;
        end else begin
            m_min = ref_next(m_min, 1'b0);
            m_gat = ref_next(m_gat, 1'b1);
        end
        check({req, " min"},   int'(cnt_min), m_min);
        check({req, " gated"}, int'(cnt_gat), m_gat);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(1'b1, 1'b0, 0, "R1 reset");
        step(1'b1, 1'b0, 0, "R1 reset");

        // R2 / R6 free running from reset; both sets must match
        for (int i = 0; i < 40; i++) begin
            step(1'b0, 1'b0, 0, "R2 count");
            check("R6 sets agree", int'(cnt_min), int'(cnt_gat));
        end

        // R3 / R4 / R7 recovery from each unused code
        for (int v = 5; v < 8; v++) begin
            step(1'b0, 1'b1, v, "R5 preload unused");
            step(1'b0, 1'b0, 0, "R3 R4 recover");
            checks++;
            if (cnt_min > 3'd4 || cnt_gat > 3'd4) begin
                errors++;
                $display("FAIL R7: actual %0d/%0d expected <=4", cnt_min, cnt_gat);
            end
            step(1'b0, 1'b0, 0, "R2 after recovery");
        end

        // R5 legal preloads, then counting continues
        for (int v = 0; v < 5; v++) begin
            step(1'b0, 1'b1, v, "R5 preload legal");
            step(1'b0, 1'b0, 0, "R2 after preload");
        end

        // R1 reset wins over a simultaneous preload
        step(1'b0, 1'b1, 3, "R5 preload");
        step(1'b1, 1'b1, 6, "R1 reset over preload");

        // R6 second run from reset
        for (int i = 0; i < 12; i++) begin
            step(1'b0, 1'b0, 0, "R6 rerun");
            check("R6 sets agree", int'(cnt_min), int'(cnt_gat));
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule